// File: doc/BRIEF.md
# Low-Voltage Reset Qualifier

This block is the digital side of a supply monitor. Two comparator flags come in from the analog section. One is high while the supply sits at or below a falling trip level. The other is high while the supply is above a higher rising trip level. Both flags are brought into the clock domain by a two-flop synchronizer. The block then decides whether to hold the chip in reset.

The reset needs a long, unbroken stretch of low supply to assert. It clears as soon as the supply is seen above the rising level for a single cycle. That lopsided rule rejects short dips on the way down and lets the chip restart quickly on the way up. While the reset is held, an active-low pin is driven low so that parts on the board are held in reset too.

Two configuration inputs set the mode. A module-enable bit turns the block on. With the block enabled and reset-enable low, the block is in polled mode: software reads the status byte and no reset is ever asserted. With both bits high, the block is in reset mode and drives the reset. The status byte is read-only and carries the synchronized low-supply flag in its top bit.

Top module: `lvr_qualifier`

## Requirements
- R1: A change on `cmp_low_i` shows in `status_o[7]` after exactly three rising clock edges: two synchronizer stages and one flag register. This holds while `cfg_enable` is 1.
- R2: A run of 8 consecutive synchronized low cycles, followed by a cycle that is not low, leaves `rst_req_o` at 0.
- R3: In reset mode (`cfg_enable`=1, `cfg_rst_en`=1), `rst_req_o` rises on the 9th consecutive synchronized low cycle. It stays high for any longer run.
- R4: Once `rst_req_o` is high, it stays high while the synchronized `cmp_high_i` is 0. This holds even after `cmp_low_i` returns to 0.
- R5: A single synchronized cycle with `cmp_high_i`=1 clears `rst_req_o` on the next edge.
- R6: `rst_pin_n_o` is always the inverse of `rst_req_o`: it is low exactly while a reset is requested.
- R7: `status_o` is 8 bits wide. Bit 7 is the low-supply flag and bits 6 to 0 always read 0. After reset, `status_o` reads 8'h00.
- R8: In polled mode (`cfg_enable`=1, `cfg_rst_en`=0), `status_o[7]` follows the synchronized `cmp_low_i`. In this mode `rst_req_o` never asserts, however long the supply stays low.
- R9: With `cfg_enable`=0, `status_o[7]` holds its last value and `rst_req_o` is 0.
- R10: Any cycle in which the synchronized `cmp_low_i` is 0 restarts the low-run count. Two runs of 5 low cycles with one gap between them therefore cause no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_enable | input | 1 | Module enable |
| cfg_rst_en | input | 1 | Reset-mode select (0 = polled) |
| cmp_low_i | input | 1 | Comparator: supply at or below the falling trip level (asynchronous) |
| cmp_high_i | input | 1 | Comparator: supply above the rising trip level (asynchronous) |
| rst_req_o | output | 1 | Chip reset request, active high |
| rst_pin_n_o | output | 1 | External reset pin drive, active low |
| status_o | output | 8 | Read-only status byte; bit 7 is the low-supply flag |

## Verification
The embedded assertions check on every cycle that:
- the run counter never passes its limit;
- the run counter clears after a non-low cycle;
- a reset rises only after the counter reports a full run;
- a reset holds while no high-side sample has been seen;
- a high-side sample releases the reset;
- the flag is frozen while the block is disabled.

Only the bench scenarios show the exact boundaries: the 8-cycle dip against the 9-cycle dip, the three-edge status latency, the gap that restarts the count, and polled mode holding through a long low. These are checked against a behavioural reference model that is compared on every clock.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  localparam int unsigned LVR_STAT_W   = 8;
  localparam int unsigned LVR_FLAG_BIT = 7;
  localparam int unsigned LVR_NCMP     = 2;
  localparam int unsigned LVR_IDX_LOW  = 0;
  localparam int unsigned LVR_IDX_HIGH = 1;

  typedef enum logic [1:0] {
    LVR_OFF    = 2'b00,
    LVR_POLLED = 2'b01,
    LVR_FORCED = 2'b11
  } lvr_mode_e;
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] d;
      if (g == 0) begin : g_first
        assign d = async_i;
      end else begin : g_next
        assign d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvr_lowcount.sv
module lvr_lowcount #(
  parameter int unsigned LIMIT = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         count_en,
  input  logic                         low_i,
  output logic [$clog2(LIMIT+1)-1:0]   cnt_o,
  output logic                         ripe_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ld;

  always_comb begin
    cnt_ld = 1'b1;
    cnt_d  = cnt_q;
    if (!count_en || !low_i) begin
      cnt_d = '0;
    end else if (cnt_q < LIM_V) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_ld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign ripe_o = count_en && low_i && (cnt_q >= LAST_V);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_V);

  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !low_i |=> cnt_q == '0);
endmodule

// File: rtl/lvr_rstctl.sv
module lvr_rstctl
  import lvr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lvr_mode_e mode_i,
  input  logic      ripe_i,
  input  logic      high_i,
  output logic      rst_o
);
  logic rst_q, rst_d;

  always_comb begin
    rst_d = rst_q;
    if (mode_i != LVR_FORCED || high_i) begin
      rst_d = 1'b0;
    end else if (ripe_i) begin
      rst_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= rst_d;
  end

  assign rst_o = rst_q;

  p_rise_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(ripe_i));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q && mode_i == LVR_FORCED && !high_i |=> rst_q);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    high_i |=> !rst_q);

  p_polled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == LVR_POLLED |=> !rst_q);
endmodule

// File: rtl/lvr_qualifier.sv
module lvr_qualifier
  import lvr_pkg::*;
#(
  parameter int unsigned LOW_RUN     = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic                  cfg_rst_en,
  input  logic                  cmp_low_i,
  input  logic                  cmp_high_i,
  output logic                  rst_req_o,
  output logic                  rst_pin_n_o,
  output logic [LVR_STAT_W-1:0] status_o
);
  localparam int unsigned CW = $clog2(LOW_RUN + 1);

  logic [LVR_NCMP-1:0] cmp_raw, cmp_s;
  logic [CW-1:0]       run_cnt;
  logic                ripe;
  logic                rst_int;
  logic                flag_q, flag_d;
  lvr_mode_e           mode;

  assign cmp_raw[LVR_IDX_LOW]  = cmp_low_i;
  assign cmp_raw[LVR_IDX_HIGH] = cmp_high_i;

  always_comb begin
    if (!cfg_enable)     mode = LVR_OFF;
    else if (cfg_rst_en) mode = LVR_FORCED;
    else                 mode = LVR_POLLED;
  end

  lvr_sync #(.WIDTH(LVR_NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_raw),
    .sync_o  (cmp_s)
  );

  lvr_lowcount #(.LIMIT(LOW_RUN)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (cfg_enable),
    .low_i    (cmp_s[LVR_IDX_LOW]),
    .cnt_o    (run_cnt),
    .ripe_o   (ripe)
  );

  lvr_rstctl u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode),
    .ripe_i (ripe),
    .high_i (cmp_s[LVR_IDX_HIGH]),
    .rst_o  (rst_int)
  );

  always_comb begin
    flag_d = flag_q;
    if (cfg_enable) flag_d = cmp_s[LVR_IDX_LOW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    status_o               = '0;
    status_o[LVR_FLAG_BIT] = flag_q;
  end

  assign rst_req_o   = rst_int;
  assign rst_pin_n_o = ~rst_int;

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> $stable(flag_q));

  p_off_no_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !rst_req_o);

  p_count_for_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(run_cnt) >= CW'(LOW_RUN - 1));
endmodule

// File: tb/lvr_qualifier_tb.sv
module lvr_qualifier_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0;
  logic cfg_rst_en = 1'b0;
  logic cmp_low_i = 1'b0;
  logic cmp_high_i = 1'b0;
  logic rst_req_o, rst_pin_n_o;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lvr_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rst_en(cfg_rst_en),
    .cmp_low_i(cmp_low_i), .cmp_high_i(cmp_high_i),
    .rst_req_o(rst_req_o), .rst_pin_n_o(rst_pin_n_o), .status_o(status_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: history queues of sampled inputs and a run length.
  bit low_hist[$];
  bit high_hist[$];
  int m_run;
  bit m_rst;
  bit m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_hist = {1'b0, 1'b0};
      high_hist = {1'b0, 1'b0};
      m_run = 0; m_rst = 0; m_flag = 0;
    end else begin
      bit ls, hs;
      ls = low_hist[low_hist.size()-2];
      hs = high_hist[high_hist.size()-2];
      low_hist.push_back(cmp_low_i);
      high_hist.push_back(cmp_high_i);
      void'(low_hist.pop_front());
      void'(high_hist.pop_front());
      if (cfg_enable && ls) m_run = m_run + 1; else m_run = 0;
      if (!cfg_enable || !cfg_rst_en || hs) m_rst = 0;
      else if (m_run >= 9) m_rst = 1;
      if (cfg_enable) m_flag = ls;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 per-cycle reset", {7'b0, rst_req_o}, {7'b0, m_rst});
      check("R6 per-cycle pin", {7'b0, rst_pin_n_o}, {7'b0, !m_rst});
      check("R7 per-cycle status", status_o, {m_flag, 7'b0});
    end
  end

  task automatic hold(input bit lo, input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_low_i = lo;
      cmp_high_i = hi;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset status", status_o, 8'h00);
    check("R6 reset pin", {7'b0, rst_pin_n_o}, 8'h01);
    rst_n = 1'b1;
    cfg_enable = 1'b1;
    cfg_rst_en = 1'b1;
    hold(0, 0, 3);

    // R1: three-edge latency to the status flag
    hold(1, 0, 1);
    @(negedge clk); @(negedge clk);
    check("R1 flag after two edges", status_o, 8'h00);
    @(negedge clk);
    check("R1 flag after three edges", status_o, 8'h80);
    hold(0, 0, 8);

    // R2: 8-cycle dip
    hold(1, 0, 8); hold(0, 0, 6);
    check("R2 eight-cycle dip", {7'b0, rst_req_o}, 8'h00);

    // R10: gap restarts the run
    hold(1, 0, 5); hold(0, 0, 1); hold(1, 0, 5); hold(0, 0, 6);
    check("R10 split dip", {7'b0, rst_req_o}, 8'h00);

    // R3: 9-cycle dip
    hold(1, 0, 9); hold(0, 0, 6);
    check("R3 nine-cycle dip", {7'b0, rst_req_o}, 8'h01);
    check("R6 pin low in reset", {7'b0, rst_pin_n_o}, 8'h00);

    // R4: hold between thresholds
    hold(0, 0, 12);
    check("R4 held between levels", {7'b0, rst_req_o}, 8'h01);

    // R5: one-cycle release
    hold(0, 1, 1); hold(0, 0, 6);
    check("R5 one-cycle release", {7'b0, rst_req_o}, 8'h00);
    check("R6 pin released", {7'b0, rst_pin_n_o}, 8'h01);

    // R8: polled mode
    cfg_rst_en = 1'b0;
    hold(1, 0, 20);
    check("R8 polled no reset", {7'b0, rst_req_o}, 8'h00);
    check("R8 polled pin high", {7'b0, rst_pin_n_o}, 8'h01);
    check("R8 polled flag set", status_o, 8'h80);
    hold(0, 0, 6);
    check("R8 polled flag clear", status_o, 8'h00);

    // R9: disabled module
    cfg_rst_en = 1'b1;
    hold(1, 0, 6);
    cfg_enable = 1'b0;
    hold(0, 0, 6);
    check("R9 flag holds", status_o, 8'h80);
    hold(1, 0, 20);
    check("R9 no reset when off", {7'b0, rst_req_o}, 8'h00);
    cfg_enable = 1'b1;
    hold(0, 0, 6);
    check("R9 flag resumes", status_o, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule